// File: doc/BRIEF.md
# Serial Byte-Store Slave with Four-Byte Page Buffer

This block is a two-wire serial slave in front of a 256-byte memory, which is held here as a register array. It recognises its own device address: a fixed upper nibble and three strap bits. In a write transaction it takes an 8-bit word address and then data bytes. The data bytes go into a four-slot page buffer. At STOP the buffer is committed to the array, and the slave then stays busy for a timed write cycle. During that cycle it refuses every access.

Reads come from a shared address counter. A current read starts at the counter. A random read loads the counter with a dummy write and then issues a repeated START. When the master acknowledges a byte, the transfer continues sequentially. A write-guard input blocks commits when it is high, so data can be accepted on the bus and still leave the memory unchanged. The write-cycle length is a parameter counted in system clocks. SCL and SDA are sampled by the system clock. The slave pulls SDA low through `sda_oe_o`.

Top module: `i2c_page_mem`

## Requirements
- R1: The slave acknowledges an address byte only when bits 7..4 equal 1010 and bits 3..1 equal `strap_i`. Bit 0 set to 1 selects a read. Any other address is not acknowledged, and the slave stays off the bus until the next START.
- R2: In a write, the slave acknowledges the byte after the address as the word address (0..255). It acknowledges each later byte as data. After STOP, a single data byte reads back from the word address.
- R3: Each data byte advances only the low two bits of the word address. A fifth or later byte wraps within the four-byte page and overwrites the byte buffered earlier in that slot. The upper six address bits never change.
- R4: A STOP that ends a write holding at least one data byte commits the buffered bytes. The slave then stays busy for `WCYC_CLKS` clocks. While busy it does not acknowledge its address, and it acknowledges normally once the cycle has ended.
- R5: When `wr_guard_i` is high at STOP, data bytes are still acknowledged but are discarded. Memory is unchanged and no busy cycle starts.
- R6: After any access the address counter holds one past the last location written or read. A read that sends no word address returns the byte at the counter.
- R7: A write made of only a word address, followed by a repeated START or a STOP, loads the counter and starts no write cycle. A following read returns that location.
- R8: When the master acknowledges a read byte, the slave sends the next location. The counter wraps from 255 to 0.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more. The slave changes SDA only while SCL is low.
- R10: After reset SDA is released, the slave is not busy, the counter is 0 and every location reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| scl_i | input | 1 | serial clock line as seen on the bus |
| sda_i | input | 1 | serial data line as seen on the bus |
| strap_i | input | 3 | device address strap bits |
| wr_guard_i | input | 1 | high blocks commits to memory |
| sda_oe_o | output | 1 | high pulls SDA low |

## Verification
The bench targets these cases:
- Page writes longer than four bytes. A design that carried the increment into bit 2 would spill into the next page instead of overwriting the first slot.
- Probing the address straight after STOP. A slave that ignored its busy state would acknowledge there.
- Guarded writes. A design that committed anyway would change later read-back values. One that started a busy cycle would refuse the next address.
- Sequential reads across address 255, and reads that end with a master no-acknowledge. These expose a counter that saturates, or a slave that keeps driving a ninth data bit.

// File: rtl/i2c_page_mem.sv
module i2c_page_mem #(
  parameter int WCYC_CLKS = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wr_guard_i,
  output logic       sda_oe_o
);
  localparam int CW = $clog2(WCYC_CLKS + 1);
  localparam int DEPTH = 256;
  localparam int PAGE = 4;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADR, S_WDAT, S_RDAT} st_t;

  logic [2:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_s, sda_p;
  assign scl_s = scl_q[1];
  assign scl_p = scl_q[2];
  assign sda_s = sda_q[1];
  assign sda_p = sda_q[2];

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  st_t st, nxt;
  logic [3:0] bcnt;
  logic [7:0] shreg, ptr;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pval;
  logic mack;
  logic [CW-1:0] busy_cnt;
  logic busy, hit;

  assign busy = busy_cnt != '0;
  assign hit  = shreg[7:4] == 4'b1010 && shreg[3:1] == strap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      st <= S_IDLE;
      nxt <= S_IDLE;
      bcnt <= '0;
      shreg <= '0;
      ptr <= '0;
      pval <= '0;
      mack <= 1'b0;
      busy_cnt <= '0;
      sda_oe_o <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (start_c) begin
        st <= S_DEV;
        bcnt <= '0;
        sda_oe_o <= 1'b0;
        pval <= '0;
      end else if (stop_c) begin
        st <= S_IDLE;
        bcnt <= '0;
        sda_oe_o <= 1'b0;
        pval <= '0;
        if (pval != '0 && !wr_guard_i) begin
          for (int i = 0; i < PAGE; i++)
            if (pval[i]) mem[{ptr[7:2], 2'(i)}] <= pbuf[i];
          busy_cnt <= CW'(WCYC_CLKS);
        end
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bcnt < 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            bcnt <= bcnt + 1'b1;
          end else if (bcnt == 4'd8 && st == S_RDAT) begin
            mack <= ~sda_s;
            bcnt <= 4'd9;
          end
        end
        if (scl_fall) begin
          if (st == S_RDAT && bcnt != 4'd0 && bcnt < 4'd8) begin
            sda_oe_o <= ~shreg[7];
          end else if (st == S_RDAT && bcnt == 4'd8) begin
            sda_oe_o <= 1'b0;
          end else if (bcnt == 4'd8) begin
            bcnt <= 4'd9;
            case (st)
              S_DEV: begin
                if (hit && !busy) begin
                  sda_oe_o <= 1'b1;
                  nxt <= shreg[0] ? S_RDAT : S_WADR;
                end else begin
                  st <= S_IDLE;
                end
              end
              S_WADR: begin
                ptr <= shreg;
                sda_oe_o <= 1'b1;
                nxt <= S_WDAT;
              end
              default: begin
                pbuf[ptr[1:0]] <= shreg;
                pval[ptr[1:0]] <= 1'b1;
                ptr[1:0] <= ptr[1:0] + 2'd1;
                sda_oe_o <= 1'b1;
                nxt <= S_WDAT;
              end
            endcase
          end else if (bcnt == 4'd9) begin
            bcnt <= '0;
            sda_oe_o <= 1'b0;
            if (st == S_RDAT && !mack) begin
              st <= S_IDLE;
            end else begin
              st <= nxt;
              if (nxt == S_RDAT) begin
                shreg <= mem[ptr];
                sda_oe_o <= ~mem[ptr][7];
                ptr <= ptr + 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_page_mem_chk.sv
module i2c_page_mem_chk #(
  parameter int WCYC_CLKS = 500000,
  parameter int CW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          oe,
  input logic          guard,
  input logic [2:0]    st,
  input logic [CW-1:0] busy_cnt
);
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !scl_s);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !oe);

  a_r4_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0 && st == 3'd1) |-> !oe);

  a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_cnt) == '0 && busy_cnt != '0) |-> busy_cnt == CW'(WCYC_CLKS));

  a_r5_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_cnt) == '0 && busy_cnt != '0) |-> $past(!guard));
endmodule

bind i2c_page_mem i2c_page_mem_chk #(.WCYC_CLKS(WCYC_CLKS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .oe(sda_oe_o),
  .guard(wr_guard_i), .st(st), .busy_cnt(busy_cnt)
);

// File: tb/sim_i2c_page_mem.sv
module sim_i2c_page_mem;
  localparam int WCYC = 300;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, guard = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_page_mem #(.WCYC_CLKS(WCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .strap_i(strap), .wr_guard_i(guard), .sda_oe_o(sda_oe)
  );

  logic [7:0] model [256];
  logic [7:0] mptr;
  int nchk = 0, nbad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic i2c_bit(input bit v, output bit s);
    m_sda = v; qw; m_scl = 1'b1; qw; s = sda_bus; qw; m_scl = 1'b0; qw;
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) i2c_bit(b[i], s);
    i2c_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin i2c_bit(1'b1, s); b[i] = s; end
    i2c_bit(!give_ack, s);
  endtask

  task automatic go_start; m_sda = 1'b1; qw; m_scl = 1'b1; qw; m_sda = 1'b0; qw; m_scl = 1'b0; qw; endtask
  task automatic go_stop;  m_sda = 1'b0; qw; m_scl = 1'b1; qw; m_sda = 1'b1; qw; qw; endtask
  task automatic wait_cycle; repeat (WCYC + 60) @(negedge clk); endtask

  function automatic logic [7:0] dev(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic mwrite(input logic [7:0] wa, input int n, input logic [7:0] d [8], input string tag);
    bit ack;
    go_start;
    send(dev(0), ack); chk(ack, {tag, " R1 addr ack"}, ack, 1);
    send(wa, ack);     chk(ack, {tag, " R2 word ack"}, ack, 1);
    mptr = wa;
    for (int k = 0; k < n; k++) begin
      send(d[k], ack); chk(ack, {tag, " R2 data ack"}, ack, 1);
      if (!guard) model[mptr] = d[k];
      mptr[1:0] = mptr[1:0] + 2'd1;
    end
    go_stop;
    if (n > 0 && !guard) wait_cycle;
  endtask

  task automatic mread(input bit rnd, input logic [7:0] wa, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    go_start;
    if (rnd) begin
      send(dev(0), ack); chk(ack, {tag, " R7 addr ack"}, ack, 1);
      send(wa, ack);     chk(ack, {tag, " R7 word ack"}, ack, 1);
      mptr = wa;
      go_start;
    end
    send(dev(1), ack); chk(ack, {tag, " R6 read addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv(k < n - 1, b);
      chk(b == model[mptr], {tag, " R8 data"}, b, model[mptr]);
      mptr++;
    end
    chk(!sda_oe, {tag, " R9 released after nack"}, sda_oe, 0);
    go_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [8];
    bit ack;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    mptr = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sda_oe, "R10 sda released", sda_oe, 0);
    mread(0, 8'h00, 2, "R10 reset read");

    strap = 3'b101;
    go_start; send({4'b1010, 3'b011, 1'b0}, ack); go_stop;
    chk(!ack, "R1 wrong strap nacked", ack, 0);
    go_start; send({4'b0100, strap, 1'b0}, ack); go_stop;
    chk(!ack, "R1 wrong nibble nacked", ack, 0);
    go_start; send({4'b1010, strap, 1'b0}, ack); go_stop;
    chk(ack, "R1 own address acked", ack, 1);

    d[0] = 8'h5A;
    mwrite(8'h37, 1, d, "R2 byte");
    mread(1, 8'h37, 1, "R2 readback");

    d[0] = 8'hC3;
    mwrite(8'h80, 0, d, "R4 pre");
    go_start; send(dev(0), ack); send(8'h80, ack); send(d[0], ack); go_stop;
    model[8'h80] = 8'hC3; mptr = 8'h81;
    go_start; send(dev(0), ack); go_stop;
    chk(!ack, "R4 busy refuses address", ack, 0);
    wait_cycle;
    go_start; send(dev(0), ack); go_stop;
    chk(ack, "R4 acked after cycle", ack, 1);
    mread(1, 8'h80, 1, "R4 commit");

    for (int k = 0; k < 6; k++) d[k] = 8'h10 + 8'(k);
    mwrite(8'h46, 6, d, "R3 page wrap");
    mread(1, 8'h44, 6, "R3 page read");

    guard = 1'b1;
    d[0] = 8'hEE; d[1] = 8'hDD;
    mwrite(8'h37, 2, d, "R5 guarded");
    go_start; send(dev(0), ack); go_stop;
    chk(ack, "R5 no busy after guarded write", ack, 1);
    guard = 1'b0;
    mread(1, 8'h37, 1, "R5 unchanged");

    mread(1, 8'h44, 1, "R6 set");
    mread(0, 8'h00, 1, "R6 current read");

    mwrite(8'h90, 0, d, "R7 dummy");
    go_start; send(dev(0), ack); go_stop;
    chk(ack, "R7 no cycle after dummy write", ack, 1);
    mread(0, 8'h00, 1, "R7 counter loaded");

    for (int k = 0; k < 4; k++) d[k] = 8'hA0 + 8'(k);
    mwrite(8'hFC, 4, d, "R8 top page");
    for (int k = 0; k < 4; k++) d[k] = 8'hB0 + 8'(k);
    mwrite(8'h00, 4, d, "R8 bottom page");
    mread(1, 8'hFE, 4, "R8 wrap read");
    mread(0, 8'h00, 1, "R9 after nack");

    for (int it = 0; it < 14; it++) begin
      int op;
      op = int'($urandom_range(0, 2));
      if (op == 0) begin
        int n;
        n = int'($urandom_range(1, 6));
        for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
        guard = ($urandom_range(0, 4) == 0);
        mwrite(8'($urandom), n, d, "R3 random write");
        guard = 1'b0;
      end else if (op == 1) begin
        mread(1, 8'($urandom), int'($urandom_range(1, 3)), "R8 random read");
      end else begin
        mread(0, 8'h00, int'($urandom_range(1, 2)), "R6 random current");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule